// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Inserter

This block writes per-channel transmit signaling into an outgoing DS1 payload stream of 24 channels. Each channel has a 4-bit ABCD signaling word. The word comes from one of two places. A processor port can write and read it through two register pages of 16 offsets each. A serial per-timeslot input can also deliver a nibble with a valid strobe, and the block keeps the latest nibble for each channel. A source-select input chooses which of the two stores feeds the inserter.

A frame counter tracks the position within the superframe. It is reset by a superframe-start pulse and advanced by a frame-advance pulse. A mode input picks the 12-frame D4 superframe or the 24-frame ESF superframe. Payload octets arrive one per clock with a valid strobe and a channel index. In a signaling frame, the block replaces the least significant bit of the octet (bit position 8, sent last) with the bit that frame calls for. Every other octet is passed through unchanged. Output octets appear one clock later with the same strobe and channel index.

Top module: `rbs_inserter`

## Requirements
- R1: Register page 0 (`cpu_pg_hi`=0) offsets 0..15 hold the words of channel indices 0..15. Page 1 offsets 0..7 hold channel indices 16..23. A write stores `cpu_wdata[3:0]`, and `cpu_rdata` returns that value combinationally for the addressed word.
- R2: `cpu_rdata[7:4]` always reads zero. Page 1 offsets 8..15 read as zero, and a write to them changes no stored word.
- R3: In a channel word, bit 3 is A, bit 2 is B, bit 1 is C and bit 0 is D. In both modes, bit 0 of the octet is replaced by A in frame 6 and by B in frame 12.
- R4: With `esf_mode`=1, bit 0 of the octet is replaced by C in frame 18 and by D in frame 24.
- R5: With `esf_mode`=0, the counter wraps after frame 12, and bits C and D are never inserted.
- R6: Frames are numbered from 1, and the counter is 1 after reset. `sf_start` sets the counter to 1 and takes precedence over `frame_adv`. `frame_adv` increments the counter, which wraps from 12 (D4) or 24 (ESF) back to 1.
- R7: With `src_cpu`=1, the inserted bits come from the register words. With `src_cpu`=0, they come from the serial store.
- R8: When `ser_vld`=1 and `ser_ch` is 0..23, the serial store keeps `ser_abcd` for that channel. A strobe with `ser_ch` of 24 or more is ignored.
- R9: With `sig_en`=0, every octet passes through unmodified.
- R10: `out_vld` and `out_ch` equal `in_vld` and `in_ch` one clock earlier. `out_oct[7:1]` always equals the input's bits 7:1. Octets outside signaling frames, and octets with `in_ch` of 24 or more, pass through unchanged.
- R11: After reset, `out_vld` is 0 and all stored words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_pg_hi | input | 1 | Page select: 0 = channels 0..15, 1 = channels 16..23 |
| cpu_off | input | 4 | Offset within the page |
| cpu_wdata | input | 8 | Write data; bits 3:0 are ABCD |
| cpu_rdata | output | 8 | Read data for the addressed word |
| ser_vld | input | 1 | Serial nibble strobe |
| ser_ch | input | 5 | Channel index of the serial nibble |
| ser_abcd | input | 4 | Serial ABCD nibble |
| src_cpu | input | 1 | 1 = register source, 0 = serial source |
| sig_en | input | 1 | Global signaling enable |
| esf_mode | input | 1 | 1 = 24-frame ESF, 0 = 12-frame D4 |
| sf_start | input | 1 | Superframe-start pulse |
| frame_adv | input | 1 | Frame-advance pulse |
| in_vld | input | 1 | Input octet valid |
| in_ch | input | 5 | Input channel index |
| in_oct | input | 8 | Input payload octet |
| out_vld | output | 1 | Output octet valid |
| out_ch | output | 5 | Output channel index |
| out_oct | output | 8 | Output payload octet |

## Verification
The bench builds the block with its default parameters: 24 channels, 16 words per page and a 24-frame ESF superframe. These values put the unmapped upper half of page 1, the D4 wrap at frame 12 and the ESF frames 18 and 24 within reach. A behavioural model predicts every output octet from random payloads. The bench runs full superframes in both modes from each source, with signaling disabled, with out-of-range channel indices, and with a restart pulse that collides with a frame advance.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
    typedef enum logic [2:0] {SL_NONE, SL_A, SL_B, SL_C, SL_D} sig_slot_e;

    // Pick the signaling bit named by a slot out of an ABCD word (A at bit 3).
    function automatic logic pick_bit(input logic [3:0] abcd, input sig_slot_e slot);
        case (slot)
            SL_A:    return abcd[3];
            SL_B:    return abcd[2];
            SL_C:    return abcd[1];
            SL_D:    return abcd[0];
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/rbs_frame_ctr.sv
module rbs_frame_ctr #(
    parameter int SF_ESF = 24,
    localparam int SF_D4 = SF_ESF / 2,
    localparam int FR_W  = $clog2(SF_ESF + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sf_start,
    input  logic            frame_adv,
    input  logic            esf_mode,
    output logic [FR_W-1:0] frame
);
    typedef struct packed {
        logic [FR_W-1:0] frame;
    } fr_state_t;

    fr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sf_start) begin
            st_d.frame = FR_W'(1);
        end else if (frame_adv) begin
            if (int'(st_q.frame) >= (esf_mode ? SF_ESF : SF_D4))
                st_d.frame = FR_W'(1);
            else
                st_d.frame = st_q.frame + FR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{frame: FR_W'(1)};
        else        st_q <= st_d;
    end

    assign frame = st_q.frame;

    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sf_start |=> int'(frame) == 1);
    p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(frame) >= 1 && int'(frame) <= SF_ESF);
    p_d4_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_adv && !sf_start && !esf_mode && int'(frame) >= SF_D4) |=> int'(frame) == 1);
endmodule

// File: rtl/rbs_sig_store.sv
module rbs_sig_store #(
    parameter int NUM_CH  = 24,
    parameter int PAGE_CH = 16,
    parameter int SIG_W   = 4,
    parameter int WORD_W  = 8,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int OFF_W  = $clog2(PAGE_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_pg_hi,
    input  logic [OFF_W-1:0]  cpu_off,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    input  logic              ser_vld,
    input  logic [CH_W-1:0]   ser_ch,
    input  logic [SIG_W-1:0]  ser_abcd,
    input  logic              src_cpu,
    input  logic [CH_W-1:0]   look_ch,
    output logic [SIG_W-1:0]  look_abcd
);
    typedef struct packed {
        logic [NUM_CH-1:0][SIG_W-1:0] cpu;
        logic [NUM_CH-1:0][SIG_W-1:0] ser;
    } store_t;

    store_t          st_d, st_q;
    int              map_sum;
    logic            map_ok;
    logic [CH_W-1:0] map_idx;
    logic            unused_wdata;

    assign unused_wdata = ^cpu_wdata[WORD_W-1:SIG_W];

    always_comb begin
        map_sum = int'(cpu_off) + (cpu_pg_hi ? PAGE_CH : 0);
        map_ok  = map_sum < NUM_CH;
        map_idx = CH_W'(map_sum);
    end

    always_comb begin
        st_d = st_q;
        if (cpu_wr && map_ok)
            st_d.cpu[map_idx] = cpu_wdata[SIG_W-1:0];
        if (ser_vld && int'(ser_ch) < NUM_CH)
            st_d.ser[ser_ch] = ser_abcd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_rdata = map_ok ? WORD_W'(st_q.cpu[map_idx]) : '0;

    always_comb begin
        if (int'(look_ch) >= NUM_CH) look_abcd = '0;
        else if (src_cpu)            look_abcd = st_q.cpu[look_ch];
        else                         look_abcd = st_q.ser[look_ch];
    end

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[WORD_W-1:SIG_W] == '0);
    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cpu_off) + (cpu_pg_hi ? PAGE_CH : 0) >= NUM_CH) |-> cpu_rdata == '0);
    p_wr_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && map_ok) |=> ($stable(cpu_pg_hi) && $stable(cpu_off)) |->
            cpu_rdata[SIG_W-1:0] == $past(cpu_wdata[SIG_W-1:0]));
endmodule

// File: rtl/rbs_inserter.sv
module rbs_inserter #(
    parameter int NUM_CH  = 24,
    parameter int PAGE_CH = 16,
    parameter int SIG_W   = 4,
    parameter int WORD_W  = 8,
    parameter int SF_ESF  = 24,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int OFF_W  = $clog2(PAGE_CH),
    localparam int FR_W   = $clog2(SF_ESF + 1),
    localparam int STEP   = SF_ESF / 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_pg_hi,
    input  logic [OFF_W-1:0]  cpu_off,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    input  logic              ser_vld,
    input  logic [CH_W-1:0]   ser_ch,
    input  logic [SIG_W-1:0]  ser_abcd,
    input  logic              src_cpu,
    input  logic              sig_en,
    input  logic              esf_mode,
    input  logic              sf_start,
    input  logic              frame_adv,
    input  logic              in_vld,
    input  logic [CH_W-1:0]   in_ch,
    input  logic [WORD_W-1:0] in_oct,
    output logic              out_vld,
    output logic [CH_W-1:0]   out_ch,
    output logic [WORD_W-1:0] out_oct
);
    import rbs_pkg::*;

    typedef struct packed {
        logic              vld;
        logic [CH_W-1:0]   ch;
        logic [WORD_W-1:0] oct;
    } out_t;

    logic [FR_W-1:0]  frame;
    logic [SIG_W-1:0] look_abcd;
    sig_slot_e        slot;
    out_t             st_d, st_q;

    rbs_frame_ctr #(.SF_ESF(SF_ESF)) u_frame (
        .clk(clk), .rst_n(rst_n), .sf_start(sf_start), .frame_adv(frame_adv),
        .esf_mode(esf_mode), .frame(frame)
    );

    rbs_sig_store #(.NUM_CH(NUM_CH), .PAGE_CH(PAGE_CH), .SIG_W(SIG_W), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_pg_hi(cpu_pg_hi), .cpu_off(cpu_off),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ser_vld(ser_vld), .ser_ch(ser_ch),
        .ser_abcd(ser_abcd), .src_cpu(src_cpu), .look_ch(in_ch), .look_abcd(look_abcd)
    );

    // Which signaling bit, if any, the current frame carries.
    always_comb begin
        slot = SL_NONE;
        if (int'(frame) == STEP)                     slot = SL_A;
        else if (int'(frame) == 2 * STEP)            slot = SL_B;
        else if (esf_mode && int'(frame) == 3 * STEP) slot = SL_C;
        else if (esf_mode && int'(frame) == 4 * STEP) slot = SL_D;
    end

    always_comb begin
        st_d.vld = in_vld;
        st_d.ch  = in_ch;
        st_d.oct = in_oct;
        if (in_vld && sig_en && slot != SL_NONE && int'(in_ch) < NUM_CH)
            st_d.oct[0] = pick_bit(look_abcd, slot);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_ch  = st_q.ch;
    assign out_oct = st_q.oct;

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_vld == $past(in_vld)) && (out_ch == $past(in_ch)));
    p_high_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_oct[WORD_W-1:1] == $past(in_oct[WORD_W-1:1]));
    p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !sig_en) |=> out_oct == $past(in_oct));
    p_d4_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !esf_mode && int'(frame) != STEP && int'(frame) != 2 * STEP)
            |=> out_oct == $past(in_oct));
    p_bad_ch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && int'(in_ch) >= NUM_CH) |=> out_oct == $past(in_oct));
endmodule

// File: tb/sim_rbs_inserter.sv
module sim_rbs_inserter;
    localparam int CLK_PER = 10;

    logic       clk = 0, rst_n = 0;
    logic       cpu_wr = 0, cpu_pg_hi = 0;
    logic [3:0] cpu_off = 0;
    logic [7:0] cpu_wdata = 0, cpu_rdata;
    logic       ser_vld = 0;
    logic [4:0] ser_ch = 0;
    logic [3:0] ser_abcd = 0;
    logic       src_cpu = 1, sig_en = 0, esf_mode = 1, sf_start = 0, frame_adv = 0;
    logic       in_vld = 0;
    logic [4:0] in_ch = 0;
    logic [7:0] in_oct = 0;
    logic       out_vld;
    logic [4:0] out_ch;
    logic [7:0] out_oct;

    always #(CLK_PER / 2) clk = ~clk;

    rbs_inserter u0 (.*);

    int    total = 0, bad = 0;
    bit    done = 0;
    string cur_req = "R11";
    int    m_cpu[24], m_ser[24];
    int    m_frame = 1;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: predict output, step the model, compare half a period later.
    task automatic cyc();
        int e_vld, e_ch, e_oct, w, b;
        e_vld = in_vld; e_ch = in_ch; e_oct = in_oct;
        if (in_vld && sig_en && in_ch < 24) begin
            w = src_cpu ? m_cpu[in_ch] : m_ser[in_ch];
            b = -1;
            if (m_frame == 6) b = (w >> 3) & 1;
            if (m_frame == 12) b = (w >> 2) & 1;
            if (esf_mode && m_frame == 18) b = (w >> 1) & 1;
            if (esf_mode && m_frame == 24) b = w & 1;
            if (b >= 0) e_oct = (e_oct & 8'hFE) | b;
        end
        @(posedge clk);
        if (cpu_wr && (cpu_pg_hi ? 16 + cpu_off : cpu_off) < 24)
            m_cpu[cpu_pg_hi ? 16 + cpu_off : cpu_off] = cpu_wdata & 15;
        if (ser_vld && ser_ch < 24) m_ser[ser_ch] = ser_abcd;
        if (sf_start) m_frame = 1;
        else if (frame_adv) m_frame = (m_frame >= (esf_mode ? 24 : 12)) ? 1 : m_frame + 1;
        @(negedge clk);
        if (e_vld) check(cur_req, {out_vld, out_ch, out_oct}, {1'b1, e_ch[4:0], e_oct[7:0]});
        else       check(cur_req, out_vld, 0);
    endtask

    task automatic cpu_write(input bit pg, input int off, input int data);
        cpu_wr = 1; cpu_pg_hi = pg; cpu_off = off[3:0]; cpu_wdata = data[7:0];
        cyc();
        cpu_wr = 0;
    endtask

    task automatic cpu_read(input string req, input bit pg, input int off);
        int idx;
        cpu_pg_hi = pg; cpu_off = off[3:0];
        #1;
        idx = pg ? 16 + off : off;
        check(req, cpu_rdata, idx < 24 ? m_cpu[idx] : 0);
    endtask

    task automatic ser_put(input int ch, input int v);
        ser_vld = 1; ser_ch = ch[4:0]; ser_abcd = v[3:0];
        cyc();
        ser_vld = 0;
    endtask

    task automatic one_frame(input bit bad_ch);
        for (int c = 0; c < 24; c++) begin
            in_vld = 1; in_ch = bad_ch ? 5'(24 + c % 8) : c[4:0]; in_oct = 8'($urandom);
            cyc();
        end
        in_vld = 0; frame_adv = 1;
        cyc();
        frame_adv = 0;
    endtask

    task automatic restart();
        sf_start = 1; cyc(); sf_start = 0;
    endtask

    initial begin
        foreach (m_cpu[i]) begin m_cpu[i] = 0; m_ser[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R11";
        check("R11", out_vld, 0);
        for (int o = 0; o < 16; o++) cpu_read("R11", 0, o);
        cyc();

        cur_req = "R1";
        for (int o = 0; o < 16; o++) cpu_write(0, o, 8'hA0 | ((o * 7 + 3) & 15));
        for (int o = 0; o < 8; o++) cpu_write(1, o, 8'h50 | ((o * 5 + 9) & 15));
        for (int o = 0; o < 16; o++) cpu_read("R1", 0, o);
        for (int o = 0; o < 8; o++) cpu_read("R1", 1, o);
        cur_req = "R2";
        for (int o = 8; o < 16; o++) cpu_write(1, o, 8'hFF);
        for (int o = 0; o < 16; o++) cpu_read("R2", 1, o);
        for (int o = 0; o < 16; o++) cpu_read("R2", 0, o);

        cur_req = "R3"; sig_en = 1; esf_mode = 1; src_cpu = 1;
        restart();
        cur_req = "R4";
        for (int f = 0; f < 24; f++) one_frame(0);
        for (int o = 0; o < 16; o++) cpu_write(0, o, 15 - o);
        for (int f = 0; f < 24; f++) one_frame(0);

        cur_req = "R5"; esf_mode = 0;
        restart();
        for (int f = 0; f < 26; f++) one_frame(0);

        cur_req = "R8";
        for (int c = 0; c < 24; c++) ser_put(c, (c * 11 + 6) & 15);
        ser_put(25, 15); ser_put(31, 15);
        cur_req = "R7"; src_cpu = 0; esf_mode = 1;
        restart();
        for (int f = 0; f < 24; f++) one_frame(0);
        src_cpu = 1;
        for (int f = 0; f < 6; f++) one_frame(0);

        cur_req = "R9"; sig_en = 0;
        restart();
        for (int f = 0; f < 24; f++) one_frame(0);

        cur_req = "R10"; sig_en = 1;
        restart();
        for (int f = 0; f < 24; f++) one_frame(1);

        cur_req = "R6";
        for (int f = 0; f < 9; f++) one_frame(0);
        sf_start = 1; frame_adv = 1; cyc(); sf_start = 0; frame_adv = 0;
        for (int f = 0; f < 12; f++) one_frame(0);
        esf_mode = 0;
        for (int f = 0; f < 14; f++) one_frame(0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            bad++;
            $display("FAIL R10 watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule